// File: doc/BRIEF.md
# Video AGC and Clamp Controller

This block closes the digital side of the gain and black-level loops of a video digitizer. Every sample clock it takes one 8-bit converter code and two timing strobes. The sync strobe is high over the sync tip. The porch strobe is high over the back porch. From these inputs it drives two charge/discharge command pairs: one for the external gain capacitor and one for the external clamp capacitor. Each command is registered, so it follows its sample by one clock.

The block has two modes. In coarse acquisition, the gain loop uses a wide tolerance around the sync target, so it can pull a weak signal in quickly. Each line ends on the falling edge of the porch strobe. At that point the block compares the average code under the sync strobe with the average code under the porch strobe. Once enough consecutive lines show a clear separation, the block moves to tracking mode. Tracking mode holds the sync tip at code 0 within one code. A long run of failing lines sends the block back to coarse acquisition. The clamp loop aims the back porch at code 64 in both modes. A peak-white limiter overrides everything else and lowers the gain whenever a sample reaches code 248.

Top module: `vid_agc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are all 0: both command pairs hold and `tracking_o` is 0, meaning coarse mode.
- R2: Each command output reflects the code and strobes sampled at the previous rising clock edge. Commands are one-hot or zero, where up = charge, down = discharge, and both low = hold.
- R3: A sample of code 248 or higher gives gain down on the next clock, in either mode and whatever the strobes are. Gain up is never set at the same time. A sample below 248 with the sync strobe low gives gain hold. This covers nominal content up to code 213.
- R4: In tracking mode (`tracking_o` = 1), a sample below 248 taken while the sync strobe is high gives gain up if the code is 2 or more, and gain hold if the code is 0 or 1.
- R5: While the porch strobe is high, codes below 63 give clamp up, codes above 65 give clamp down, and codes 63 to 65 give clamp hold. While the porch strobe is low, the clamp holds. This applies in both modes.
- R6: In coarse mode, a sample below 248 taken while the sync strobe is high gives gain up if the code is 9 or more, and gain hold if the code is 8 or less.
- R7: A line ends in the cycle where the porch strobe is sampled low after being high. The line is good only if both strobes covered at least one sample since the previous line end, and the mean porch code minus the mean sync code is at least 32. The means are compared exactly, not truncated. In the line-end cycle itself, a sample under the sync strobe belongs to the next line.
- R8: In coarse mode, the end of the 16th consecutive good line sets `tracking_o` to 1 on the next clock. A bad line restarts the count.
- R9: In tracking mode, the end of the 64th consecutive bad line sets `tracking_o` to 0 on the next clock. A good line restarts that count. The mode changes only at line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_code_i | input | 8 | Converter output code |
| gate_sync_i | input | 1 | High over the sync tip |
| gate_porch_i | input | 1 | High over the back porch |
| gain_up_o | output | 1 | Charge the gain capacitor |
| gain_dn_o | output | 1 | Discharge the gain capacitor |
| clamp_up_o | output | 1 | Charge the clamp capacitor |
| clamp_dn_o | output | 1 | Discharge the clamp capacitor |
| tracking_o | output | 1 | 1 = tracking mode, 0 = coarse acquisition |

## Verification
The hardest situations to reach from the ports are the mode boundaries. These are the sixteenth good line, a line whose mean separation is exactly 32 codes reached with unequal samples, and the sixty-fourth bad line after a run that one good line restarted. The stimulus builds whole lines from strobe pulses and chooses the sync and porch codes to land on or just beside the separation limit. It also injects one line with no sync pulse at all, and then counts lines up to the thresholds. A behavioural model that runs alongside the design predicts every output on every clock. Directed checks then confirm the mode flag at each boundary.

// File: rtl/vagc_pkg.sv
package vagc_pkg;

    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_TRACK  = 1'b1
    } vagc_mode_e;

    // one-hot or zero: up = charge, dn = discharge, both low = hold
    typedef struct packed {
        logic up;
        logic dn;
    } vagc_cmd_t;

    typedef struct packed {
        logic done;
        logic good;
    } vagc_line_t;

    function automatic vagc_cmd_t cmd_hold();
        vagc_cmd_t c;
        c.up = 1'b0;
        c.dn = 1'b0;
        return c;
    endfunction

    function automatic vagc_cmd_t cmd_up();
        vagc_cmd_t c;
        c.up = 1'b1;
        c.dn = 1'b0;
        return c;
    endfunction

    function automatic vagc_cmd_t cmd_dn();
        vagc_cmd_t c;
        c.up = 1'b0;
        c.dn = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/vagc_line_judge.sv
module vagc_line_judge
    import vagc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int SEP_CODES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              gate_a_i,
    input  logic              gate_b_i,
    output vagc_line_t        verdict_o
);
    localparam int SUM_W  = DATA_W + CNT_W;
    localparam int PROD_W = SUM_W + CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic              gb_q;
    logic [SUM_W-1:0]  sum_a, sum_b;
    logic [CNT_W-1:0]  cnt_a, cnt_b;
    logic [PROD_W-1:0] lhs, rhs;

    // mean(b) - mean(a) >= SEP  <=>  sum_b*cnt_a >= sum_a*cnt_b + SEP*cnt_a*cnt_b
    always_comb begin
        lhs = PROD_W'(sum_b) * PROD_W'(cnt_a);
        rhs = PROD_W'(sum_a) * PROD_W'(cnt_b)
            + PROD_W'(SEP_CODES) * PROD_W'(cnt_a) * PROD_W'(cnt_b);
        verdict_o.done = gb_q & ~gate_b_i;
        verdict_o.good = (cnt_a != '0) && (cnt_b != '0) && (lhs >= rhs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gb_q  <= 1'b0;
            sum_a <= '0;
            sum_b <= '0;
            cnt_a <= '0;
            cnt_b <= '0;
        end else begin
            gb_q <= gate_b_i;
            if (verdict_o.done) begin
                sum_a <= gate_a_i ? SUM_W'(sample_i) : '0;
                cnt_a <= gate_a_i ? CNT_W'(1) : '0;
                sum_b <= '0;
                cnt_b <= '0;
            end else begin
                if (gate_a_i && cnt_a != CNT_MAX) begin
                    sum_a <= sum_a + SUM_W'(sample_i);
                    cnt_a <= cnt_a + CNT_W'(1);
                end
                if (gate_b_i && cnt_b != CNT_MAX) begin
                    sum_b <= sum_b + SUM_W'(sample_i);
                    cnt_b <= cnt_b + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vagc_mode_fsm.sv
module vagc_mode_fsm
    import vagc_pkg::*;
#(
    parameter int LOCK_LINES   = 16,
    parameter int UNLOCK_LINES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  vagc_line_t verdict_i,
    output vagc_mode_e mode_o
);
    localparam int GW = $clog2(LOCK_LINES + 1);
    localparam int BW = $clog2(UNLOCK_LINES + 1);

    vagc_mode_e    mode_q;
    logic [GW-1:0] good_cnt;
    logic [BW-1:0] bad_cnt;

    assign mode_o = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_COARSE;
            good_cnt <= '0;
            bad_cnt  <= '0;
        end else if (verdict_i.done) begin
            case (mode_q)
                MODE_COARSE: begin
                    if (!verdict_i.good) begin
                        good_cnt <= '0;
                    end else if (good_cnt == GW'(LOCK_LINES - 1)) begin
                        mode_q   <= MODE_TRACK;
                        good_cnt <= '0;
                        bad_cnt  <= '0;
                    end else begin
                        good_cnt <= good_cnt + GW'(1);
                    end
                end
                default: begin
                    if (verdict_i.good) begin
                        bad_cnt <= '0;
                    end else if (bad_cnt == BW'(UNLOCK_LINES - 1)) begin
                        mode_q   <= MODE_COARSE;
                        good_cnt <= '0;
                        bad_cnt  <= '0;
                    end else begin
                        bad_cnt <= bad_cnt + BW'(1);
                    end
                end
            endcase
        end
    end

    AST_MODE_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
        (!$past(verdict_i.done)) |-> $stable(mode_q))
        else $error("mode changed outside a line end"); // R9

endmodule

// File: rtl/vagc_cmd_gen.sv
module vagc_cmd_gen
    import vagc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_CODE   = 0,
    parameter int BLACK_CODE  = 64,
    parameter int PEAK_CODE   = 248,
    parameter int TRACK_BAND  = 1,
    parameter int COARSE_BAND = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              gate_a_i,
    input  logic              gate_b_i,
    input  vagc_mode_e        mode_i,
    output vagc_cmd_t         gain_o,
    output vagc_cmd_t         clamp_o
);
    localparam logic [DATA_W-1:0] PEAK_L     = DATA_W'(PEAK_CODE);
    localparam logic [DATA_W-1:0] TRACK_LIM  = DATA_W'(SYNC_CODE + TRACK_BAND);
    localparam logic [DATA_W-1:0] COARSE_LIM = DATA_W'(SYNC_CODE + COARSE_BAND);
    localparam logic [DATA_W-1:0] CLAMP_LO   = DATA_W'(BLACK_CODE - TRACK_BAND);
    localparam logic [DATA_W-1:0] CLAMP_HI   = DATA_W'(BLACK_CODE + TRACK_BAND);

    vagc_cmd_t         gain_d, clamp_d, gain_q, clamp_q;
    logic [DATA_W-1:0] sync_lim;

    always_comb begin
        sync_lim = (mode_i == MODE_TRACK) ? TRACK_LIM : COARSE_LIM;
        gain_d   = cmd_hold();
        if (sample_i >= PEAK_L)
            gain_d = cmd_dn();
        else if (gate_a_i && sample_i > sync_lim)
            gain_d = cmd_up();

        clamp_d = cmd_hold();
        if (gate_b_i) begin
            if (sample_i < CLAMP_LO)
                clamp_d = cmd_up();
            else if (sample_i > CLAMP_HI)
                clamp_d = cmd_dn();
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q  <= cmd_hold();
            clamp_q <= cmd_hold();
        end else begin
            gain_q  <= gain_d;
            clamp_q <= clamp_d;
        end
    end

    assign gain_o  = gain_q;
    assign clamp_o = clamp_q;

    AST_PEAK_GAIN_DN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sample_i) >= PEAK_L) |-> (gain_q.dn && !gain_q.up))
        else $error("peak sample did not force gain down"); // R3
    AST_GAIN_UP_GATED: assert property (@(posedge clk) disable iff (rst)
        gain_q.up |-> $past(gate_a_i))
        else $error("gain up without sync strobe"); // R4
    AST_CLAMP_GATED: assert property (@(posedge clk) disable iff (rst)
        (!$past(gate_b_i)) |-> (!clamp_q.up && !clamp_q.dn))
        else $error("clamp moved outside porch strobe"); // R5
    AST_CLAMP_DEADBAND: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(gate_b_i) && $past(sample_i) >= CLAMP_LO
         && $past(sample_i) <= CLAMP_HI) |-> (!clamp_q.up && !clamp_q.dn))
        else $error("clamp moved inside dead band"); // R5

endmodule

// File: rtl/vid_agc_ctrl.sv
module vid_agc_ctrl
    import vagc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 8,
    parameter int SEP_CODES    = 32,
    parameter int LOCK_LINES   = 16,
    parameter int UNLOCK_LINES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] adc_code_i,
    input  logic              gate_sync_i,
    input  logic              gate_porch_i,
    output logic              gain_up_o,
    output logic              gain_dn_o,
    output logic              clamp_up_o,
    output logic              clamp_dn_o,
    output logic              tracking_o
);
    vagc_line_t verdict;
    vagc_mode_e mode;
    vagc_cmd_t  gain, clamp;

    vagc_line_judge #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .SEP_CODES(SEP_CODES)
    ) u_judge (
        .clk(clk), .rst(rst), .sample_i(adc_code_i),
        .gate_a_i(gate_sync_i), .gate_b_i(gate_porch_i), .verdict_o(verdict)
    );

    vagc_mode_fsm #(
        .LOCK_LINES(LOCK_LINES), .UNLOCK_LINES(UNLOCK_LINES)
    ) u_fsm (
        .clk(clk), .rst(rst), .verdict_i(verdict), .mode_o(mode)
    );

    vagc_cmd_gen #(
        .DATA_W(DATA_W)
    ) u_cmd (
        .clk(clk), .rst(rst), .sample_i(adc_code_i),
        .gate_a_i(gate_sync_i), .gate_b_i(gate_porch_i), .mode_i(mode),
        .gain_o(gain), .clamp_o(clamp)
    );

    assign gain_up_o  = gain.up;
    assign gain_dn_o  = gain.dn;
    assign clamp_up_o = clamp.up;
    assign clamp_dn_o = clamp.dn;
    assign tracking_o = (mode == MODE_TRACK);

endmodule

// File: tb/vid_agc_ctrl_tb.sv
module vid_agc_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code = 8'd0;
    logic       ga = 1'b0, gb = 1'b0;
    logic       gain_up, gain_dn, clamp_up, clamp_dn, tracking;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_mode = 0, m_good = 0, m_bad = 0, m_gbq = 0;
    int m_sa = 0, m_sb = 0, m_ca = 0, m_cb = 0;
    int e_gu, e_gd, e_cu, e_cd, e_tr;

    always #4 clk = ~clk;

    vid_agc_ctrl u_dut (
        .clk(clk), .rst(rst), .adc_code_i(code),
        .gate_sync_i(ga), .gate_porch_i(gb),
        .gain_up_o(gain_up), .gain_dn_o(gain_dn),
        .clamp_up_o(clamp_up), .clamp_dn_o(clamp_dn),
        .tracking_o(tracking)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, predict, wait for edge, compare
    task automatic step(input bit r, input int s, input bit a, input bit b);
        int done, good;
        string gtag;
        rst = r; code = 8'(s); ga = a; gb = b;
        if (r) begin
            e_gu = 0; e_gd = 0; e_cu = 0; e_cd = 0;
            m_mode = 0; m_good = 0; m_bad = 0; m_gbq = 0;
            m_sa = 0; m_sb = 0; m_ca = 0; m_cb = 0;
            gtag = "R1";
        end else begin
            e_gu = 0; e_gd = 0;
            if (s >= 248) begin e_gd = 1; gtag = "R3"; end
            else begin
                gtag = (m_mode == 1) ? "R4" : "R6";
                if (a && s > ((m_mode == 1) ? 1 : 8)) e_gu = 1;
            end
            e_cu = (b && s < 63) ? 1 : 0;
            e_cd = (b && s > 65) ? 1 : 0;
            done = (m_gbq == 1 && !b) ? 1 : 0;
            good = (m_ca > 0 && m_cb > 0 && (m_sb * m_ca - m_sa * m_cb >= 32 * m_ca * m_cb)) ? 1 : 0;
            if (done == 1) begin
                if (m_mode == 0) begin
                    if (good == 1) begin
                        m_good++;
                        if (m_good == 16) begin m_mode = 1; m_good = 0; m_bad = 0; end
                    end else m_good = 0;
                end else begin
                    if (good == 0) begin
                        m_bad++;
                        if (m_bad == 64) begin m_mode = 0; m_good = 0; m_bad = 0; end
                    end else m_bad = 0;
                end
                m_sa = a ? s : 0; m_ca = a ? 1 : 0; m_sb = 0; m_cb = 0;
            end else begin
                if (a && m_ca < 255) begin m_sa += s; m_ca++; end
                if (b && m_cb < 255) begin m_sb += s; m_cb++; end
            end
            m_gbq = b;
        end
        e_tr = m_mode;
        @(posedge clk);
        #1;
        chk(gain_up,  e_gu, {gtag, " R2 gain_up"});
        chk(gain_dn,  e_gd, {gtag, " R2 gain_dn"});
        chk(clamp_up, e_cu, r ? "R1 clamp_up" : "R5 clamp_up");
        chk(clamp_dn, e_cd, r ? "R1 clamp_dn" : "R5 clamp_dn");
        chk(tracking, e_tr, r ? "R1 tracking" : "R8 tracking");
    endtask

    task automatic line4(input int a0, input int a1, input int a2, input int a3,
                         input int bv, input bit has_a);
        for (int i = 0; i < 3; i++) step(0, 100, 0, 0);
        if (has_a) begin
            step(0, a0, 1, 0); step(0, a1, 1, 0); step(0, a2, 1, 0); step(0, a3, 1, 0);
        end
        step(0, 100, 0, 0); step(0, 100, 0, 0);
        for (int i = 0; i < 4; i++) step(0, bv, 0, 1);
        step(0, 100, 0, 0);
    endtask

    task automatic line(input int av, input int bv);
        line4(av, av, av, av, bv, 1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset holds everything even with hostile inputs
        for (int i = 0; i < 3; i++) step(1, 250, 1, 1);
        chk(tracking, 0, "R1 coarse after reset");

        // R6 coarse gain band, R3 peak, R5 clamp band
        step(0, 8, 1, 0);   chk(gain_up, 0, "R6 code 8 holds");
        step(0, 9, 1, 0);   chk(gain_up, 1, "R6 code 9 raises");
        step(0, 40, 1, 0);
        step(0, 5, 1, 0);
        step(0, 247, 1, 0); chk(gain_up, 1, "R6 code 247 under sync");
        step(0, 248, 1, 0); chk(gain_dn, 1, "R3 peak wins over sync");
        step(0, 255, 0, 1); chk(gain_dn, 1, "R3 peak outside sync");
        step(0, 213, 0, 0); chk(gain_dn | gain_up, 0, "R3 nominal holds");
        step(0, 62, 0, 1);  chk(clamp_up, 1, "R5 below band");
        step(0, 63, 0, 1);  chk(clamp_up | clamp_dn, 0, "R5 band low edge");
        step(0, 65, 0, 1);  chk(clamp_up | clamp_dn, 0, "R5 band high edge");
        step(0, 66, 0, 1);  chk(clamp_dn, 1, "R5 above band");
        step(0, 10, 0, 0);  chk(clamp_up | clamp_dn, 0, "R5 no porch strobe");
        line(200, 64);      // flush partial line

        // R7/R8: 15 good lines, then a line one code short of separation
        for (int i = 0; i < 15; i++) line(10, 64);
        chk(tracking, 0, "R8 15 good lines not enough");
        line(33, 64);       // separation 31: bad (R7)
        chk(tracking, 0, "R7 separation 31 is bad");
        for (int i = 0; i < 15; i++) line(32, 64);  // separation exactly 32
        chk(tracking, 0, "R8 count restarted by bad line");
        line4(30, 34, 31, 33, 64, 1);               // mean 32, unequal samples (R7)
        chk(tracking, 1, "R8 lock on 16th good line");

        // R4 tracking gain band
        step(0, 0, 1, 0);   chk(gain_up, 0, "R4 code 0 holds");
        step(0, 1, 1, 0);   chk(gain_up, 0, "R4 code 1 holds");
        step(0, 2, 1, 0);   chk(gain_up, 1, "R4 code 2 raises");
        step(0, 5, 0, 0);   chk(gain_up, 0, "R4 no sync strobe");
        step(0, 250, 1, 0); chk(gain_dn, 1, "R3 peak in tracking");

        // R9: 63 bad, good restarts, 63 bad, one sync-less line completes 64
        for (int i = 0; i < 63; i++) line(60, 64);
        chk(tracking, 1, "R9 63 bad lines keep tracking");
        line(0, 64);
        for (int i = 0; i < 63; i++) line(60, 64);
        chk(tracking, 1, "R9 count restarted by good line");
        line4(0, 0, 0, 0, 64, 0);                   // no sync samples: bad (R7)
        chk(tracking, 0, "R9 unlock on 64th bad line");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule